// File: doc/BRIEF.md
# Byte-Interleaving Shuffle Network

This combinational network sits between one ALU port and the general register storage. It handles the 8-bit, 16-bit and 32-bit views of a register without a barrel shifter. In storage, the two low bytes of every register are bit-interleaved. Logical bit i of byte 0 and logical bit i of byte 1 therefore sit in adjacent stored positions, while bits 31:16 keep their natural order.

On the read side, the network turns the raw stored word into a logical operand for the size that is selected. When the second byte is selected, one 2:1 multiplexer per bit pair moves it onto ALU bits 7:0. On the write side, the network scatters an ALU result back into storage order. It also produces a per-bit write-enable mask, so that a byte or halfword write leaves the rest of the register untouched. The read and write sides have independent size selects, so one register can be read while another is written.

Size encoding on both `rd_size_i` and `wr_size_i`:
- 2'b00: word
- 2'b01: halfword
- 2'b10: low byte
- 2'b11: second byte

Top module: `byte_shuffle_net`

## Requirements
- R1: On word and halfword writes, `wr_stored_o[2i]` equals result bit i and `wr_stored_o[2i+1]` equals result bit 8+i, for i = 0..7.
- R2: Bits 31:16 pass in natural order. On a word write `wr_stored_o[31:16]` equals `wr_result_i[31:16]`, and on a word read `rd_operand_o[31:16]` equals `rd_stored_i[31:16]`.
- R3: A word read (2'b00) returns the de-interleaved low 16 bits in logical order together with the upper 16 bits unchanged.
- R4: A halfword read (2'b01) returns the de-interleaved low 16 bits, with `rd_operand_o[31:16]` zero.
- R5: A low-byte read (2'b10) returns the even stored bits 0,2,..,14 on operand bits 7:0, with bits 31:8 zero.
- R6: A second-byte read (2'b11) returns the odd stored bits 1,3,..,15 (logical bits 15:8) on operand bits 7:0, with bits 31:8 zero.
- R7: A word write enables all 32 bits, and a halfword write enables exactly bits 15:0.
- R8: A low-byte write enables only stored positions 0,2,..,14, so the second byte of the register is preserved.
- R9: A second-byte write enables only stored positions 1,3,..,15, so the low byte of the register is preserved.
- R10: On byte writes, result bits 7:0 are driven on both positions of each pair (`wr_stored_o[2i]` = `wr_stored_o[2i+1]` = result bit i). On every non-word write, `wr_stored_o[31:16]` is zero.
- R11: For every size, a write merged into storage under its enables and then read back with the same size returns the written value truncated to that size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rd_stored_i | input | 32 | Raw register word in storage order |
| rd_size_i | input | 2 | Read size select |
| rd_operand_o | output | 32 | Logical operand to the ALU |
| wr_result_i | input | 32 | ALU result in logical order |
| wr_size_i | input | 2 | Write size select |
| wr_stored_o | output | 32 | Write data in storage order |
| wr_bit_en_o | output | 32 | Per-bit write enables |

## Verification
The sweeps target three kinds of error:
- **Pair order.** Walking-one patterns cross each byte and pair boundary. A network that swapped the even and odd positions of a pair, or that rotated the pairs, would move a single one into the wrong logical or stored bit.
- **Byte writes.** After each byte write, the bench reads the same merged word back as a halfword. An enable mask with the wrong parity would then corrupt the neighbouring byte, and the check would show it. The same reads show a second-byte read that took data from the low byte.
- **Zero extension.** Every narrow read is checked for zeros above its size. Every non-word write is checked for no enables in the upper half. A design that leaked stale upper bits fails these checks.

// File: rtl/byte_shuffle_pkg.sv
package byte_shuffle_pkg;
  typedef enum logic [1:0] {
    SZ_WORD    = 2'b00,
    SZ_HALF    = 2'b01,
    SZ_BYTE_LO = 2'b10,
    SZ_BYTE_HI = 2'b11
  } op_size_e;
endpackage

// File: rtl/shuf_pair_scatter.sv
module shuf_pair_scatter #(
  parameter int LANE_W = 8
) (
  input  logic [2*LANE_W-1:0] logical_i,
  output logic [2*LANE_W-1:0] stored_o
);
  for (genvar i = 0; i < LANE_W; i++) begin : g_pair
    assign stored_o[2*i]   = logical_i[i];
    assign stored_o[2*i+1] = logical_i[LANE_W+i];
  end
endmodule

// File: rtl/shuf_pair_gather.sv
module shuf_pair_gather #(
  parameter int LANE_W = 8
) (
  input  logic [2*LANE_W-1:0] stored_i,
  output logic [2*LANE_W-1:0] logical_o
);
  for (genvar i = 0; i < LANE_W; i++) begin : g_pair
    assign logical_o[i]        = stored_i[2*i];
    assign logical_o[LANE_W+i] = stored_i[2*i+1];
  end
endmodule

// File: rtl/shuf_read_path.sv
module shuf_read_path
  import byte_shuffle_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] stored_i,
  input  logic [1:0]        size_i,
  output logic [DATA_W-1:0] operand_o
);
  localparam int PAIR_W  = 2 * LANE_W;
  localparam int UPPER_W = DATA_W - PAIR_W;
  localparam int BEXT_W  = DATA_W - LANE_W;

  logic [PAIR_W-1:0] low_logical;
  logic [LANE_W-1:0] byte_pick;
  logic              pick_hi;
  op_size_e          size;

  assign size    = op_size_e'(size_i);
  assign pick_hi = (size == SZ_BYTE_HI);

  shuf_pair_gather #(.LANE_W(LANE_W)) u_gather (
    .stored_i  (stored_i[PAIR_W-1:0]),
    .logical_o (low_logical)
  );

  // one 2:1 mux per adjacent pair replaces a byte shifter
  for (genvar i = 0; i < LANE_W; i++) begin : g_pick
    assign byte_pick[i] = pick_hi ? stored_i[2*i+1] : stored_i[2*i];
  end

  always_comb begin
    unique case (size)
      SZ_WORD:    operand_o = {stored_i[DATA_W-1:PAIR_W], low_logical};
      SZ_HALF:    operand_o = {{UPPER_W{1'b0}}, low_logical};
      default:    operand_o = {{BEXT_W{1'b0}}, byte_pick};
    endcase
  end
endmodule

// File: rtl/shuf_write_path.sv
module shuf_write_path
  import byte_shuffle_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] result_i,
  input  logic [1:0]        size_i,
  output logic [DATA_W-1:0] stored_o,
  output logic [DATA_W-1:0] bit_en_o
);
  localparam int PAIR_W  = 2 * LANE_W;
  localparam int UPPER_W = DATA_W - PAIR_W;

  logic [PAIR_W-1:0] low_stored;
  logic [PAIR_W-1:0] byte_rep;
  logic [PAIR_W-1:0] even_mask;
  logic [PAIR_W-1:0] odd_mask;
  op_size_e          size;

  assign size = op_size_e'(size_i);

  shuf_pair_scatter #(.LANE_W(LANE_W)) u_scatter (
    .logical_i (result_i[PAIR_W-1:0]),
    .stored_o  (low_stored)
  );

  for (genvar i = 0; i < LANE_W; i++) begin : g_pair
    assign byte_rep[2*i]    = result_i[i];
    assign byte_rep[2*i+1]  = result_i[i];
    assign even_mask[2*i]   = 1'b1;
    assign even_mask[2*i+1] = 1'b0;
    assign odd_mask[2*i]    = 1'b0;
    assign odd_mask[2*i+1]  = 1'b1;
  end

  always_comb begin
    unique case (size)
      SZ_WORD: begin
        stored_o = {result_i[DATA_W-1:PAIR_W], low_stored};
        bit_en_o = '1;
      end
      SZ_HALF: begin
        stored_o = {{UPPER_W{1'b0}}, low_stored};
        bit_en_o = {{UPPER_W{1'b0}}, {PAIR_W{1'b1}}};
      end
      SZ_BYTE_LO: begin
        stored_o = {{UPPER_W{1'b0}}, byte_rep};
        bit_en_o = {{UPPER_W{1'b0}}, even_mask};
      end
      default: begin
        stored_o = {{UPPER_W{1'b0}}, byte_rep};
        bit_en_o = {{UPPER_W{1'b0}}, odd_mask};
      end
    endcase
  end
endmodule

// File: rtl/byte_shuffle_net.sv
module byte_shuffle_net #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] rd_stored_i,
  input  logic [1:0]        rd_size_i,
  output logic [DATA_W-1:0] rd_operand_o,
  input  logic [DATA_W-1:0] wr_result_i,
  input  logic [1:0]        wr_size_i,
  output logic [DATA_W-1:0] wr_stored_o,
  output logic [DATA_W-1:0] wr_bit_en_o
);
  shuf_read_path #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_rd (
    .stored_i  (rd_stored_i),
    .size_i    (rd_size_i),
    .operand_o (rd_operand_o)
  );

  shuf_write_path #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_wr (
    .result_i (wr_result_i),
    .size_i   (wr_size_i),
    .stored_o (wr_stored_o),
    .bit_en_o (wr_bit_en_o)
  );
endmodule

// File: rtl/byte_shuffle_net_chk.sv
module byte_shuffle_net_chk #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input logic [1:0]        rd_size_i,
  input logic [DATA_W-1:0] rd_operand_o,
  input logic [LANE_W-1:0] wr_result_lo_i,
  input logic [1:0]        wr_size_i,
  input logic [DATA_W-1:0] wr_stored_o,
  input logic [DATA_W-1:0] wr_bit_en_o
);
  localparam int PAIR_W = 2 * LANE_W;

  logic even_ok, odd_ok, rep_ok;

  always_comb begin
    even_ok = 1'b1;
    odd_ok  = 1'b1;
    rep_ok  = 1'b1;
    for (int i = 0; i < LANE_W; i++) begin
      if (wr_bit_en_o[2*i+1]) even_ok = 1'b0;
      if (wr_bit_en_o[2*i])   odd_ok  = 1'b0;
      if (wr_stored_o[2*i] != wr_result_lo_i[i] ||
          wr_stored_o[2*i+1] != wr_result_lo_i[i]) rep_ok = 1'b0;
    end
  end

  always_comb begin
    if (rd_size_i == 2'b01)
      assert_half_rd_upper_zero_R4: assert (rd_operand_o[DATA_W-1:PAIR_W] == '0);
    if (rd_size_i == 2'b10)
      assert_lo_rd_upper_zero_R5: assert (rd_operand_o[DATA_W-1:LANE_W] == '0);
    if (rd_size_i == 2'b11)
      assert_hi_rd_upper_zero_R6: assert (rd_operand_o[DATA_W-1:LANE_W] == '0);
    if (wr_size_i == 2'b00)
      assert_word_en_all_R7: assert ($countones(wr_bit_en_o) == DATA_W);
    if (wr_size_i == 2'b01)
      assert_half_en_low_R7: assert ($countones(wr_bit_en_o) == PAIR_W &&
                                     wr_bit_en_o[DATA_W-1:PAIR_W] == '0);
    if (wr_size_i == 2'b10)
      assert_lo_en_even_R8: assert ($countones(wr_bit_en_o) == LANE_W && even_ok);
    if (wr_size_i == 2'b11)
      assert_hi_en_odd_R9: assert ($countones(wr_bit_en_o) == LANE_W && odd_ok);
    if (wr_size_i[1])
      assert_byte_rep_R10: assert (rep_ok && wr_stored_o[DATA_W-1:PAIR_W] == '0);
  end
endmodule

bind byte_shuffle_net byte_shuffle_net_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
  .rd_size_i      (rd_size_i),
  .rd_operand_o   (rd_operand_o),
  .wr_result_lo_i (wr_result_i[LANE_W-1:0]),
  .wr_size_i      (wr_size_i),
  .wr_stored_o    (wr_stored_o),
  .wr_bit_en_o    (wr_bit_en_o)
);

// File: tb/tb_byte_shuffle_net.sv
module tb_byte_shuffle_net;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] rd_stored, rd_operand, wr_result, wr_stored, wr_bit_en;
  logic [1:0]  rd_size, wr_size;
  int          n_run = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  byte_shuffle_net dut (
    .rd_stored_i  (rd_stored),
    .rd_size_i    (rd_size),
    .rd_operand_o (rd_operand),
    .wr_result_i  (wr_result),
    .wr_size_i    (wr_size),
    .wr_stored_o  (wr_stored),
    .wr_bit_en_o  (wr_bit_en)
  );

  function automatic logic [31:0] gather(logic [31:0] s);
    logic [31:0] r = s;
    for (int i = 0; i < 8; i++) begin
      r[i]   = s[2*i];
      r[8+i] = s[2*i+1];
    end
    return r;
  endfunction

  function automatic logic [31:0] scatter(logic [31:0] l);
    logic [31:0] r = l;
    for (int i = 0; i < 8; i++) begin
      r[2*i]   = l[i];
      r[2*i+1] = l[8+i];
    end
    return r;
  endfunction

  function automatic logic [31:0] rep(logic [7:0] b);
    logic [31:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      r[2*i]   = b[i];
      r[2*i+1] = b[i];
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd_check(logic [31:0] s);
    logic [31:0] g = gather(s);
    rd_stored = s;
    rd_size = 2'b00; @(negedge clk); chk("R3/R2 word read", rd_operand, g);
    rd_size = 2'b01; @(negedge clk); chk("R4 half read", rd_operand, {16'h0, g[15:0]});
    rd_size = 2'b10; @(negedge clk); chk("R5 low byte read", rd_operand, {24'h0, g[7:0]});
    rd_size = 2'b11; @(negedge clk); chk("R6 second byte read", rd_operand, {24'h0, g[15:8]});
  endtask

  task automatic rt_check(logic [31:0] old, logic [31:0] d, logic [1:0] sz);
    logic [31:0] merged, exp_st, exp_en, exp_rd;
    logic [15:0] old_l;
    old_l = gather(old) & 32'hFFFF;
    wr_result = d;
    wr_size   = sz;
    @(negedge clk);
    case (sz)
      2'b00: begin exp_st = scatter(d);                 exp_en = 32'hFFFF_FFFF; exp_rd = d; end
      2'b01: begin exp_st = scatter({16'h0, d[15:0]});  exp_en = 32'h0000_FFFF; exp_rd = {16'h0, d[15:0]}; end
      2'b10: begin exp_st = rep(d[7:0]);                exp_en = 32'h0000_5555; exp_rd = {24'h0, d[7:0]}; end
      default: begin exp_st = rep(d[7:0]);              exp_en = 32'h0000_AAAA; exp_rd = {24'h0, d[7:0]}; end
    endcase
    case (sz)
      2'b00:   chk("R7 word enables", wr_bit_en, exp_en);
      2'b01:   chk("R7 half enables", wr_bit_en, exp_en);
      2'b10:   chk("R8 low byte enables", wr_bit_en, exp_en);
      default: chk("R9 second byte enables", wr_bit_en, exp_en);
    endcase
    if (sz[1]) chk("R10 byte write data", wr_stored, exp_st);
    else       chk("R1/R2 write data order", wr_stored, exp_st);
    merged = (old & ~wr_bit_en) | (wr_stored & wr_bit_en);
    rd_stored = merged;
    rd_size   = sz;
    @(negedge clk);
    chk("R11 round trip", rd_operand, exp_rd);
    if (sz == 2'b10) begin
      rd_size = 2'b01; @(negedge clk);
      chk("R8 second byte kept", rd_operand, {16'h0, old_l[15:8], d[7:0]});
    end
    if (sz == 2'b11) begin
      rd_size = 2'b01; @(negedge clk);
      chk("R9 low byte kept", rd_operand, {16'h0, d[7:0], old_l[7:0]});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rd_stored = '0; rd_size = 2'b00; wr_result = '0; wr_size = 2'b00;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R3 idle word read", rd_operand, 32'h0);
    chk("R7 idle word enables", wr_bit_en, 32'hFFFF_FFFF);
    for (int b = 0; b < 32; b++) begin
      rd_check(32'h1 << b);
      rd_check(~(32'h1 << b));
    end
    rd_check(32'h5555_5555);
    rd_check(32'hAAAA_AAAA);
    for (int sz = 0; sz < 4; sz++) begin
      for (int b = 0; b < 32; b++) begin
        rt_check(32'h0, 32'h1 << b, sz[1:0]);
        rt_check(32'hFFFF_FFFF, ~(32'h1 << b), sz[1:0]);
      end
      for (int k = 0; k < 100; k++) begin
        logic [31:0] old_v, dat;
        old_v = $urandom;
        dat   = $urandom;
        rd_check(old_v);
        rt_check(old_v, dat, sz[1:0]);
      end
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule